// File: doc/BRIEF.md
# Stream Prefetch Table Engine

This block is a small fully associative table of active data streams inside a data cache. Software issues a stream command that gives a first element address, a stride, a run-ahead in elements and a total element count. The engine loads one table entry from these values. Each entry holds four things: the address of the next element the program is expected to load (the synchronization address), the stride, the next address to prefetch, and the number of elements left.

The engine then compares every load address from the cache pipeline against all live entries at once, on two load ports. A match advances the entry by one element. If the two ports carry consecutive elements of one stream in the same cycle, the entry advances by two elements. A match may also offer one prefetch request downstream, but only when the requested address lies in a cache block other than the one last handed to the prefetch queue for that entry.

The prefetch output is a valid/ready stream with no storage. `pf_valid` and `pf_addr` are combinational from the current lookups. A request offered while `pf_ready` is low is dropped, and the table still advances. The entry's last-accepted block is left unchanged, so a later hit in the same block offers the request again. The command and load inputs are plain one-cycle strobes with no back-pressure.

Top module: `stream_prefetch_table`

## Requirements
- R1: After reset every entry is invalid, so no load produces a request.
- R2: An accepted command sets next prefetch address = first + run_ahead × stride and remaining count = total − run_ahead. For example, 0x00100000, stride 4, run-ahead 16 and total 128 give a first request at 0x00100040.
- R3: A load that matches no live synchronization address changes no entry and offers no request.
- R4: A single hit moves the synchronization address and the next prefetch address forward by one stride and decrements the count by one. The request candidate is the next prefetch address from before the hit.
- R5: A hit offers a request only when the candidate's block index (address bits above the 64-byte default block offset) differs from the block of that entry's last accepted request. The first hit after a command always offers one.
- R6: A request offered while `pf_ready` = 0 is dropped. The table still advances, and the entry's last accepted block is not updated.
- R7: When one port loads the synchronization address and the other port loads the synchronization address + stride in the same cycle, on either port, with count ≥ 2, the entry advances by two strides and the count drops by two. The candidate is the old next prefetch address + stride.
- R8: An entry whose count reaches zero becomes invalid and stops matching. A command with total ≤ run_ahead is ignored.
- R9: A command fills the lowest-numbered invalid entry. If every entry is valid, it replaces the least recently initialized entry.
- R10: A command and a lookup in the same cycle: the command wins for its target entry, and that entry ignores the lookup.
- R11: If several entries offer requests in one cycle, the lowest-numbered one is presented. The others count as not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Stream command strobe |
| cmd_addr | input | ADDR_W | First element address |
| cmd_stride | input | ADDR_W | Element stride in bytes |
| cmd_ahead | input | CNT_W | Run-ahead in elements |
| cmd_total | input | CNT_W | Total element count |
| ld0_valid | input | 1 | Load port 0 strobe |
| ld0_addr | input | ADDR_W | Load port 0 data address |
| ld1_valid | input | 1 | Load port 1 strobe |
| ld1_addr | input | ADDR_W | Load port 1 data address |
| pf_valid | output | 1 | Prefetch request offered |
| pf_ready | input | 1 | Prefetch queue can take the request |
| pf_addr | output | ADDR_W | Prefetch request address |

## Verification
The bench targets the following corner cases:

- **Ports in swapped order.** The double hit is sent with its ports in reversed order. A design that only recognises one ordering would step one element and then lose sync with the stream forever.
- **Back-pressure.** Requests are dropped and then followed by a hit in the same block. A design that records the block on offer rather than on acceptance would never re-request the lost block.
- **Command and lookup together.** A full table receives a command in the same cycle as a hit on the entry being evicted. A design that lets the lookup win would corrupt the new entry or emit a stale request.
- **Exhaustion and arbitration.** The bench also checks count exhaustion and commands with a count no larger than the run-ahead. It checks two entries competing for the single output, where a wrong loser would keep a stale block and suppress its retry.

// File: rtl/spt_pkg.sv
package spt_pkg;
  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_ONE  = 2'd1,
    HIT_TWO  = 2'd2
  } hit_e;
endpackage

// File: rtl/spt_entry.sv
module spt_entry import spt_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int OFF_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_en,
  input  logic [ADDR_W-1:0] init_sync,
  input  logic [ADDR_W-1:0] init_stride,
  input  logic [ADDR_W-1:0] init_next,
  input  logic [CNT_W-1:0]  init_cnt,
  input  logic              ld0_v,
  input  logic [ADDR_W-1:0] ld0_a,
  input  logic              ld1_v,
  input  logic [ADDR_W-1:0] ld1_a,
  input  logic              grant,
  output logic              live,
  output logic              req,
  output logic [ADDR_W-1:0] req_addr
);
  localparam int BLK_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] sync_q, stride_q, next_q, sync_plus, step;
  logic [CNT_W-1:0]  cnt_q, dec;
  logic [BLK_W-1:0]  lb_q;
  logic              vld_q, lb_v_q;
  logic              m0, m1, s0, s1;
  hit_e              kind;

  always_comb begin
    sync_plus = sync_q + stride_q;
    m0 = vld_q && ld0_v && (ld0_a == sync_q);
    m1 = vld_q && ld1_v && (ld1_a == sync_q);
    s0 = ld0_v && (ld0_a == sync_plus);
    s1 = ld1_v && (ld1_a == sync_plus);
    if (!vld_q || init_en)                                   kind = HIT_NONE;
    else if (((m0 && s1) || (m1 && s0)) && cnt_q >= CNT_W'(2)) kind = HIT_TWO;
    else if (m0 || m1)                                        kind = HIT_ONE;
    else                                                      kind = HIT_NONE;
    step     = (kind == HIT_TWO) ? (stride_q << 1) : stride_q;
    dec      = (kind == HIT_TWO) ? CNT_W'(2) : CNT_W'(1);
    req_addr = (kind == HIT_TWO) ? next_q + stride_q : next_q;
    req      = (kind != HIT_NONE) && (!lb_v_q || (req_addr[ADDR_W-1:OFF_W] != lb_q));
  end

  assign live = vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q    <= 1'b0;
      lb_v_q   <= 1'b0;
      lb_q     <= '0;
      sync_q   <= '0;
      stride_q <= '0;
      next_q   <= '0;
      cnt_q    <= '0;
    end else if (init_en) begin
      vld_q    <= 1'b1;
      lb_v_q   <= 1'b0;
      sync_q   <= init_sync;
      stride_q <= init_stride;
      next_q   <= init_next;
      cnt_q    <= init_cnt;
    end else if (kind != HIT_NONE) begin
      sync_q <= sync_q + step;
      next_q <= next_q + step;
      cnt_q  <= cnt_q - dec;
      vld_q  <= (cnt_q != dec);
      if (grant) begin
        lb_q   <= req_addr[ADDR_W-1:OFF_W];
        lb_v_q <= 1'b1;
      end
    end
  end

  AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == HIT_NONE && !init_en) |=> ($stable(sync_q) && $stable(next_q) && $stable(cnt_q))); // R3
  AST_LIVE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (cnt_q != '0)); // R8
  AST_DOUBLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == HIT_TWO) |=> (sync_q == $past(sync_q) + ($past(stride_q) << 1))); // R7
  AST_INIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    init_en |=> (vld_q && sync_q == $past(init_sync) && cnt_q == $past(init_cnt))); // R10
  AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> req); // R11
endmodule

// File: rtl/spt_victim.sv
module spt_victim #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     live,
  input  logic             fill,
  output logic [IDX_W-1:0] victim
);
  logic [IDX_W-1:0] rank_q [N];
  logic [N-1:0]     oldest;
  logic             found;

  always_comb begin
    found  = 1'b0;
    victim = '0;
    for (int i = 0; i < N; i++) begin
      oldest[i] = (rank_q[i] == '0);
      if (!live[i] && !found) begin
        victim = IDX_W'(i);
        found  = 1'b1;
      end
    end
    if (!found)
      for (int i = 0; i < N; i++)
        if (oldest[i]) victim = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) rank_q[i] <= IDX_W'(i);
    end else if (fill) begin
      for (int i = 0; i < N; i++)
        if (rank_q[i] > rank_q[victim]) rank_q[i] <= rank_q[i] - 1'b1;
      rank_q[victim] <= IDX_W'(N - 1);
    end
  end

  AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest) == 1); // R9
endmodule

// File: rtl/spt_arb.sv
module spt_arb #(
  parameter int N      = 16,
  parameter int ADDR_W = 32
) (
  input  logic [N-1:0]             req,
  input  logic [N-1:0][ADDR_W-1:0] addr,
  input  logic                     ready,
  output logic                     out_valid,
  output logic [ADDR_W-1:0]        out_addr,
  output logic [N-1:0]             grant
);
  always_comb begin
    out_valid = 1'b0;
    out_addr  = '0;
    grant     = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !out_valid) begin
        out_valid = 1'b1;
        out_addr  = addr[i];
        grant[i]  = ready;
      end
    end
  end
endmodule

// File: rtl/stream_prefetch_table.sv
module stream_prefetch_table #(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 16,
  parameter int NUM_ENTRIES = 16,
  parameter int BLOCK_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [ADDR_W-1:0] cmd_stride,
  input  logic [CNT_W-1:0]  cmd_ahead,
  input  logic [CNT_W-1:0]  cmd_total,
  input  logic              ld0_valid,
  input  logic [ADDR_W-1:0] ld0_addr,
  input  logic              ld1_valid,
  input  logic [ADDR_W-1:0] ld1_addr,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  logic                               accept;
  logic [ADDR_W-1:0]                  init_next;
  logic [CNT_W-1:0]                   init_cnt;
  logic [IDX_W-1:0]                   victim;
  logic [NUM_ENTRIES-1:0]             live, req, grant;
  logic [NUM_ENTRIES-1:0][ADDR_W-1:0] req_addr;

  assign accept    = cmd_valid && (cmd_total > cmd_ahead);
  assign init_next = cmd_addr + ADDR_W'(cmd_ahead) * cmd_stride;
  assign init_cnt  = cmd_total - cmd_ahead;

  spt_victim #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .live(live), .fill(accept), .victim(victim)
  );

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
    spt_entry #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .OFF_W(OFF_W)) u_entry (
      .clk(clk), .rst_n(rst_n),
      .init_en(accept && (victim == IDX_W'(g))),
      .init_sync(cmd_addr), .init_stride(cmd_stride),
      .init_next(init_next), .init_cnt(init_cnt),
      .ld0_v(ld0_valid), .ld0_a(ld0_addr),
      .ld1_v(ld1_valid), .ld1_a(ld1_addr),
      .grant(grant[g]), .live(live[g]), .req(req[g]), .req_addr(req_addr[g])
    );
  end

  spt_arb #(.N(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_arb (
    .req(req), .addr(req_addr), .ready(pf_ready),
    .out_valid(pf_valid), .out_addr(pf_addr), .grant(grant)
  );

  AST_REQ_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (ld0_valid || ld1_valid)); // R5
  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && pf_ready) |-> ($countones(grant) == 1)); // R11
endmodule

// File: tb/stream_prefetch_table_bench.sv
module stream_prefetch_table_bench;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, ld0_valid, ld1_valid, pf_ready;
  logic [31:0] cmd_addr, cmd_stride, ld0_addr, ld1_addr;
  logic [15:0] cmd_ahead, cmd_total;
  logic        pf_valid;
  logic [31:0] pf_addr;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model of the table state
  logic [31:0] m_sync [N], m_str [N], m_next [N];
  logic [15:0] m_cnt [N];
  logic [25:0] m_lb [N];
  bit          m_vld [N], m_lbv [N];
  int          m_rank [N];

  always #5 clk = ~clk;

  stream_prefetch_table u_stream_prefetch_table (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_stride(cmd_stride),
    .cmd_ahead(cmd_ahead), .cmd_total(cmd_total),
    .ld0_valid(ld0_valid), .ld0_addr(ld0_addr),
    .ld1_valid(ld1_valid), .ld1_addr(ld1_addr),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
  );

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_vld[i] = 0; m_lbv[i] = 0; m_rank[i] = i;
      m_sync[i] = 0; m_str[i] = 0; m_next[i] = 0; m_cnt[i] = 0; m_lb[i] = 0;
    end
  endtask

  task automatic do_reset();
    rst_n = 0; cmd_valid = 0; ld0_valid = 0; ld1_valid = 0; pf_ready = 1;
    cmd_addr = 0; cmd_stride = 0; cmd_ahead = 0; cmd_total = 0; ld0_addr = 0; ld1_addr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    model_reset();
  endtask

  task automatic step(input bit cv, input logic [31:0] ca, input logic [31:0] cs,
                      input logic [15:0] cra, input logic [15:0] ctot,
                      input bit l0v, input logic [31:0] l0a,
                      input bit l1v, input logic [31:0] l1a,
                      input bit rdy, input string tag);
    int kind [N];
    logic [31:0] raddr [N];
    bit rq [N];
    int vic, win;
    bit acc, e_v, found;
    logic [31:0] e_a;
    @(negedge clk);
    cmd_valid = cv; cmd_addr = ca; cmd_stride = cs; cmd_ahead = cra; cmd_total = ctot;
    ld0_valid = l0v; ld0_addr = l0a; ld1_valid = l1v; ld1_addr = l1a; pf_ready = rdy;
    #1;
    found = 0; vic = 0;
    for (int i = 0; i < N; i++) if (!m_vld[i] && !found) begin vic = i; found = 1; end
    if (!found) for (int i = 0; i < N; i++) if (m_rank[i] == 0) vic = i;
    acc = cv && (ctot > cra);
    win = -1;
    for (int i = 0; i < N; i++) begin
      bit a0, a1, b0, b1;
      a0 = l0v && l0a == m_sync[i];
      a1 = l1v && l1a == m_sync[i];
      b0 = l0v && l0a == m_sync[i] + m_str[i];
      b1 = l1v && l1a == m_sync[i] + m_str[i];
      kind[i] = 0;
      if (m_vld[i] && !(acc && vic == i)) begin
        if (((a0 && b1) || (a1 && b0)) && m_cnt[i] >= 2) kind[i] = 2;
        else if (a0 || a1) kind[i] = 1;
      end
      raddr[i] = (kind[i] == 2) ? m_next[i] + m_str[i] : m_next[i];
      rq[i] = (kind[i] != 0) && (!m_lbv[i] || raddr[i][31:6] != m_lb[i]);
      if (rq[i] && win < 0) win = i;
    end
    e_v = (win >= 0);
    e_a = e_v ? raddr[win] : 32'h0;
    checks++;
    if (pf_valid !== e_v || (e_v && pf_addr !== e_a)) begin
      errors++;
      $display("FAIL %s: pf_valid=%0b pf_addr=%h expected valid=%0b addr=%h", tag, pf_valid, pf_addr, e_v, e_a);
    end
    for (int i = 0; i < N; i++) begin
      if (kind[i] != 0) begin
        m_sync[i] = m_sync[i] + kind[i] * m_str[i];
        m_next[i] = m_next[i] + kind[i] * m_str[i];
        m_cnt[i]  = m_cnt[i] - 16'(kind[i]);
        m_vld[i]  = (m_cnt[i] != 0);
        if (i == win && rdy) begin m_lb[i] = raddr[i][31:6]; m_lbv[i] = 1; end
      end
    end
    if (acc) begin
      m_vld[vic] = 1; m_lbv[vic] = 0; m_sync[vic] = ca; m_str[vic] = cs;
      m_next[vic] = ca + 32'(cra) * cs; m_cnt[vic] = ctot - cra;
      for (int i = 0; i < N; i++) if (m_rank[i] > m_rank[vic]) m_rank[i]--;
      m_rank[vic] = N - 1;
    end
  endtask

  task automatic cmd(input logic [31:0] a, input logic [31:0] s, input logic [15:0] ra,
                     input logic [15:0] t, input string tag);
    step(1, a, s, ra, t, 0, 0, 0, 0, 1, tag);
  endtask

  task automatic ld(input bit v0, input logic [31:0] a0, input bit v1, input logic [31:0] a1,
                    input bit rdy, input string tag);
    step(0, 0, 0, 0, 0, v0, a0, v1, a1, rdy, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    // R1: empty table after reset
    ld(1, 32'h0, 1, 32'h0010_0000, 1, "R1 reset empty");
    // R2 and R5: initialization example, first hit always requests
    cmd(32'h0010_0000, 4, 16, 128, "R2 cmd");
    ld(1, 32'h0010_0000, 0, 0, 1, "R2 first request 0x00100040");
    if (pf_addr !== 32'h0010_0040) begin
      errors++; $display("FAIL R2: pf_addr=%h expected 00100040", pf_addr);
    end
    checks++;
    // R4 and R5: same block, no new request
    ld(1, 32'h0010_0004, 0, 0, 1, "R4 R5 same block");
    // R3: a miss is ignored, stream still in sync afterwards
    ld(1, 32'h0020_0000, 1, 32'h0010_0004, 1, "R3 miss");
    ld(1, 32'h0010_0008, 0, 0, 1, "R3 still synchronised");
    for (int k = 3; k < 16; k++) ld(1, 32'h0010_0000 + 32'(k) * 4, 0, 0, 1, "R4 R5 walk");
    // R7: double hit on swapped ports
    cmd(32'h0000_2000, 8, 8, 20, "R7 cmd");
    ld(1, 32'h0000_2008, 1, 32'h0000_2000, 1, "R7 swapped double hit");
    ld(1, 32'h0000_2010, 1, 32'h0000_2018, 1, "R7 in-order double hit");
    ld(1, 32'h0000_2020, 0, 0, 1, "R7 single after double");
    // R6: back-pressure drop then retry in same block
    cmd(32'h0000_4000, 16, 4, 100, "R6 cmd");
    ld(1, 32'h0000_4000, 0, 0, 0, "R6 dropped");
    ld(1, 32'h0000_4010, 0, 0, 1, "R6 retried");
    ld(1, 32'h0000_4020, 0, 0, 1, "R6 accepted block suppressed");
    // R8: exhaustion and ignored command
    do_reset();
    cmd(32'h0000_9000, 4, 2, 4, "R8 cmd");
    ld(1, 32'h0000_9000, 0, 0, 1, "R8 hit one");
    ld(1, 32'h0000_9004, 0, 0, 1, "R8 hit two");
    ld(1, 32'h0000_9008, 0, 0, 1, "R8 exhausted");
    cmd(32'h0000_A000, 4, 3, 3, "R8 short cmd");
    ld(1, 32'h0000_A000, 0, 0, 1, "R8 short ignored");
    // R11: two entries compete
    do_reset();
    cmd(32'h0000_A000, 4, 16, 40, "R11 cmd a");
    cmd(32'h0000_B000, 4, 16, 40, "R11 cmd b");
    ld(1, 32'h0000_A000, 1, 32'h0000_B000, 1, "R11 lowest wins");
    ld(1, 32'h0000_A004, 1, 32'h0000_B004, 1, "R11 loser retries");
    // R9 and R10: full table replacement
    do_reset();
    for (int j = 0; j < N; j++) cmd(32'h0001_0000 + 32'(j) * 32'h1000, 4, 1, 50, "R9 fill");
    step(1, 32'h0008_0000, 4, 1, 50, 1, 32'h0001_0000, 0, 0, 1, "R10 init beats lookup");
    ld(1, 32'h0001_0004, 0, 0, 1, "R9 oldest replaced");
    ld(1, 32'h0001_1000, 0, 0, 1, "R9 next entry intact");
    ld(1, 32'h0008_0000, 0, 0, 1, "R9 new stream live");
    // random mix
    do_reset();
    for (int c = 0; c < 4000; c++) begin
      int r, k;
      logic [31:0] a, b;
      r = $urandom % 10;
      if (r < 2) begin
        cmd(32'h0010_0000 + (($urandom % 2048) << 2), 32'd4 << ($urandom % 6),
            16'($urandom % 12), 16'($urandom % 40 + 1), "R2 R9 random cmd");
      end else begin
        k = $urandom % N;
        a = m_vld[k] ? m_sync[k] : 32'h0010_0000 + (($urandom % 2048) << 2);
        b = ($urandom % 2) ? a + m_str[k] : 32'h0010_0000 + (($urandom % 2048) << 2);
        if ($urandom % 2)
          step(r == 9, 32'h0010_0000 + (($urandom % 2048) << 2), 8, 2, 20,
               1, a, ($urandom % 3) != 0, b, ($urandom % 4) != 0, "R4 R5 R6 R7 R10 random");
        else
          step(0, 0, 0, 0, 0, ($urandom % 3) != 0, b, 1, a, ($urandom % 4) != 0, "R3 R7 R11 random");
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule